// File: doc/BRIEF.md
# Sub-Second Prescaler with Deferred Divider Reset

This block is the fraction-of-a-second stage of a real-time clock. A one-cycle enable, `osc_en`, marks each period of the 32.768 kHz timebase. The block counts these pulses from 0 to `DIV-1`. Each wrap of the count moves a BCD seconds value forward by one and gives a one-cycle `sec_tick`. When the seconds value passes from 59 to 00, it also gives a `min_carry` pulse for the minutes stage that follows. Software can read the current fraction of the second in hundredths, as a BCD byte.

Two requests can zero the divider so that the clock can be aligned to an outside time source. The first is a software request. It is held pending and takes effect when the current register-access command ends, which the block sees as `cmd_active` going low. The second is a hardware request. It is armed by a register bit and fires when the synchronized `evt_pin` reaches a chosen level. A typical source for this pin is a one-pulse-per-second reference.

Neither request stops the divider while it waits. Zeroing the divider never drops a seconds carry that is already pending. Only a write to the seconds register removes such a carry.

Top module: `subsec_prescaler`

## Requirements
- R1: Each `osc_en` cycle moves the divider forward by one. It wraps from `DIV-1` to 0. In the cycle after a wrap, `sec_tick` is high for exactly one cycle, and at the end of that cycle the seconds value goes up by one in BCD.
- R2: A read at address 3 returns the fraction of the second, floor(count*100/DIV), as two BCD digits. A write to address 3 has no effect.
- R3: The seconds value at address 0 is read and written in BCD. It wraps from 0x59 to 0x00, and `min_carry` pulses in the same cycle as that `sec_tick`.
- R4: Writing 1 to bit 0 of address 1 makes a software reset pending, and bit 0 reads back as 1. The divider is zeroed at the first clock edge where `cmd_active` is low after being high, and the bit then clears itself. If no request is pending, the end of a command has no effect.
- R5: While either reset request is pending, the divider keeps counting.
- R6: A seconds carry that is pending when the divider is zeroed is still applied. A write to address 0 in the same cycle as a pending carry stores the written value, drops the carry and suppresses `sec_tick`.
- R7: Writing 1 to bit 0 of address 2 arms the event reset. Bit 6 of address 2 selects the active level (1 = high, 0 = low). `evt_pin` passes through two flops. The divider is zeroed at the third clock edge after the pin reaches the active level, and the arm bit then clears itself.
- R8: Bits 5:4 of address 2 are stored and read back. They do not change whether the event reset fires or how long it takes.
- R9: Writing 0 to bit 0 of address 2 before the event cancels the armed reset. A later event then leaves the divider unchanged.
- R10: After reset, all four addresses read 0x00 and `sec_tick` and `min_carry` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-cycle enable per timebase period |
| cmd_active | input | 1 | High while a register-access command is in progress |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 seconds, 1 control, 2 event control, 3 fraction |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `reg_addr` (combinational) |
| evt_pin | input | 1 | Asynchronous external event input |
| sec_tick | output | 1 | One-cycle pulse when the seconds value advances |
| min_carry | output | 1 | One-cycle pulse when seconds wrap from 59 to 00 |

## Verification
The assertions assume that software writes only valid BCD seconds (tens digit 0 to 5, units digit 0 to 9). They also assume that the control register is not rewritten in the same cycle that a command ends, and that `DIV` is at least 2, so two wraps can never fall on back-to-back cycles. The stimulus writes only BCD seconds values from the legal range. It writes the control register only while `cmd_active` is high and lowers `cmd_active` in a separate later cycle. It changes `evt_pin` at falling clock edges, one level change at a time, with `osc_en` held low, so the zeroing latency can be counted exactly.

// File: rtl/subsec_pkg.sv
`timescale 1ns/1ps
package subsec_pkg;
  localparam logic [1:0] ADDR_SEC  = 2'd0;
  localparam logic [1:0] ADDR_CTL  = 2'd1;
  localparam logic [1:0] ADDR_EVT  = 2'd2;
  localparam logic [1:0] ADDR_FRAC = 2'd3;

  // next BCD seconds value, wrapping 59 -> 00
  function automatic logic [7:0] bcd_sec_next(logic [7:0] v);
    if (v[3:0] == 4'd9) begin
      if (v[6:4] == 3'd5) return 8'h00;
      return {1'b0, v[6:4] + 3'd1, 4'h0};
    end
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // divider count scaled to hundredths of a second
  function automatic int unsigned hundredths(int unsigned c, int unsigned div);
    return (c * 100) / div;
  endfunction

  // two-digit BCD of a value below 100
  function automatic logic [7:0] to_bcd99(int unsigned v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction
endpackage

// File: rtl/subsec_sync2.sv
`timescale 1ns/1ps
module subsec_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= 1'b0;
      q_sync <= 1'b0;
    end else begin
      stage1 <= d_async;
      q_sync <= stage1;
    end
  end
endmodule

// File: rtl/subsec_divider.sv
`timescale 1ns/1ps
module subsec_divider #(
  parameter int unsigned DIV = 32768,
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          osc_en,
  input  logic          zero,
  output logic [CW-1:0] cnt,
  output logic          roll
);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  assign roll = osc_en && !zero && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (zero)   cnt <= '0;
    else if (roll)   cnt <= '0;
    else if (osc_en) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/subsec_seconds.sv
`timescale 1ns/1ps
module subsec_seconds
  import subsec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       roll,
  input  logic       wr_sec,
  input  logic [7:0] wdata,
  output logic [7:0] sec_val,
  output logic       carry_pend,
  output logic       tick,
  output logic       wrap
);
  assign tick = carry_pend && !wr_sec;
  assign wrap = tick && (sec_val == 8'h59);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_val    <= 8'h00;
      carry_pend <= 1'b0;
    end else if (wr_sec) begin
      sec_val    <= {1'b0, wdata[6:0]};
      carry_pend <= 1'b0;
    end else begin
      if (carry_pend) sec_val <= bcd_sec_next(sec_val);
      carry_pend <= roll;
    end
  end
endmodule

// File: rtl/subsec_prescaler.sv
`timescale 1ns/1ps
module subsec_prescaler
  import subsec_pkg::*;
#(
  parameter int unsigned DIV = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       cmd_active,
  input  logic       wr_en,
  input  logic [1:0] reg_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       evt_pin,
  output logic       sec_tick,
  output logic       min_carry
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;
  logic          roll, zero;
  logic          cmd_d, cmd_fall;
  logic          sw_pend, sw_hit;
  logic          evt_arm, evt_pol, evt_s, evt_hit;
  logic [1:0]    evt_filt;
  logic [7:0]    sec_val;
  logic          carry_pend;
  logic          wr_sec, wr_ctl, wr_evt;

  assign wr_sec = wr_en && (reg_addr == ADDR_SEC);
  assign wr_ctl = wr_en && (reg_addr == ADDR_CTL);
  assign wr_evt = wr_en && (reg_addr == ADDR_EVT);

  // command end detection and deferred software reset
  assign cmd_fall = cmd_d && !cmd_active;
  assign sw_hit   = sw_pend && cmd_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_d   <= 1'b0;
      sw_pend <= 1'b0;
    end else begin
      cmd_d <= cmd_active;
      if (wr_ctl)      sw_pend <= wr_data[0];
      else if (sw_hit) sw_pend <= 1'b0;
    end
  end

  // event path: raw level after synchronizer, filter bits bypassed
  subsec_sync2 u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (evt_pin),
    .q_sync  (evt_s)
  );

  assign evt_hit = evt_arm && (evt_s == evt_pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_arm  <= 1'b0;
      evt_pol  <= 1'b0;
      evt_filt <= 2'b00;
    end else if (wr_evt) begin
      evt_arm  <= wr_data[0];
      evt_pol  <= wr_data[6];
      evt_filt <= wr_data[5:4];
    end else if (evt_hit) begin
      evt_arm <= 1'b0;
    end
  end

  assign zero = sw_hit || evt_hit;

  subsec_divider #(.DIV(DIV)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .osc_en (osc_en),
    .zero   (zero),
    .cnt    (cnt),
    .roll   (roll)
  );

  subsec_seconds u_sec (
    .clk        (clk),
    .rst_n      (rst_n),
    .roll       (roll),
    .wr_sec     (wr_sec),
    .wdata      (wr_data),
    .sec_val    (sec_val),
    .carry_pend (carry_pend),
    .tick       (sec_tick),
    .wrap       (min_carry)
  );

  always_comb begin
    unique case (reg_addr)
      ADDR_SEC:  rd_data = sec_val;
      ADDR_CTL:  rd_data = {7'd0, sw_pend};
      ADDR_EVT:  rd_data = {1'b0, evt_pol, evt_filt, 3'd0, evt_arm};
      default:   rd_data = to_bcd99(hundredths(32'(cnt), DIV));
    endcase
  end
endmodule

// File: rtl/subsec_prescaler_chk.sv
`timescale 1ns/1ps
module subsec_prescaler_chk
  import subsec_pkg::*;
#(
  parameter int unsigned DIV = 32768,
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          osc_en,
  input logic          wr_en,
  input logic [1:0]    reg_addr,
  input logic [7:0]    wr_data,
  input logic          sec_tick,
  input logic          min_carry,
  input logic [CW-1:0] cnt,
  input logic          sw_pend,
  input logic          cmd_fall,
  input logic          evt_arm,
  input logic          evt_hit,
  input logic [7:0]    sec_val,
  input logic          carry_pend
);
  logic wr_sec_c, wr_ctl_c, wr_evt_c, zero_c;
  assign wr_sec_c = wr_en && (reg_addr == ADDR_SEC);
  assign wr_ctl_c = wr_en && (reg_addr == ADDR_CTL);
  assign wr_evt_c = wr_en && (reg_addr == ADDR_EVT);
  assign zero_c   = (sw_pend && cmd_fall) || evt_hit;

  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < DIV);

  p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  p_sec_bcd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_val[3:0] <= 4'd9) && (sec_val[7:4] <= 4'd5));

  p_min_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    min_carry |-> (sec_tick && sec_val == 8'h59));

  p_sw_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_pend && cmd_fall && !wr_ctl_c) |=> (cnt == '0 && !sw_pend));

  p_keep_counting_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_pend || evt_arm) && !zero_c && osc_en && 32'(cnt) != DIV - 1)
      |=> cnt == CW'($past(cnt) + 1'b1));

  p_carry_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_pend && !wr_sec_c) |=> sec_val == bcd_sec_next($past(sec_val)));

  p_evt_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_hit && !wr_evt_c) |=> (cnt == '0 && !evt_arm));

  p_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt_c && !wr_data[0]) |=> !evt_arm);
endmodule

bind subsec_prescaler subsec_prescaler_chk #(.DIV(DIV)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .osc_en     (osc_en),
  .wr_en      (wr_en),
  .reg_addr   (reg_addr),
  .wr_data    (wr_data),
  .sec_tick   (sec_tick),
  .min_carry  (min_carry),
  .cnt        (cnt),
  .sw_pend    (sw_pend),
  .cmd_fall   (cmd_fall),
  .evt_arm    (evt_arm),
  .evt_hit    (evt_hit),
  .sec_val    (sec_val),
  .carry_pend (carry_pend)
);

// File: tb/subsec_prescaler_test.sv
`timescale 1ns/1ps
module subsec_prescaler_test;
  localparam int unsigned DIV = 400;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0;
  logic       cmd_active = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] reg_addr = 2'd3;
  logic [7:0] wr_data = 8'h00;
  logic       evt_pin = 1'b0;
  logic [7:0] rd_data;
  logic       sec_tick, min_carry;

  int checks = 0;
  int fails = 0;
  int ticks = 0;
  int mins = 0;

  always #2.5 clk = ~clk;

  subsec_prescaler #(.DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .cmd_active(cmd_active),
    .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
    .evt_pin(evt_pin), .sec_tick(sec_tick), .min_carry(min_carry)
  );

  always @(posedge clk) begin
    if (rst_n && sec_tick)  ticks++;
    if (rst_n && min_carry) mins++;
  end

  // {start seconds, wraps of the divider, expected seconds, expected minute carries}
  localparam logic [31:0] VEC [6] = '{
    {8'h00, 8'd1,  8'h01, 8'd0},
    {8'h09, 8'd1,  8'h10, 8'd0},
    {8'h58, 8'd2,  8'h00, 8'd1},
    {8'h59, 8'd1,  8'h00, 8'd1},
    {8'h45, 8'd20, 8'h05, 8'd1},
    {8'h30, 8'd5,  8'h35, 8'd0}
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; reg_addr = 2'd3;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #0.5;
    v = rd_data;
    reg_addr = 2'd3;
  endtask

  task automatic run(int n);
    osc_en = 1'b1;
    repeat (n) @(negedge clk);
    osc_en = 1'b0;
  endtask

  // zero the divider through a software request ended by a command
  task automatic zero_div();
    @(negedge clk);
    cmd_active = 1'b1;
    wr(2'd1, 8'h01);
    cmd_active = 1'b0;
    @(negedge clk);
  endtask

  function automatic int frac_exp(int c);
    return ((c * 100 / DIV) / 10) * 16 + (c * 100 / DIV) % 10;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    int t0, m0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(2'd0, v); check("R10 sec", v, 8'h00);
    rd(2'd1, v); check("R10 ctl", v, 8'h00);
    rd(2'd2, v); check("R10 evt", v, 8'h00);
    rd(2'd3, v); check("R10 frac", v, 8'h00);
    check("R10 tick", {sec_tick, min_carry}, 0);

    // R1 / R3 seconds table
    for (int i = 0; i < 6; i++) begin
      zero_div();
      wr(2'd0, VEC[i][31:24]);
      t0 = ticks; m0 = mins;
      run(int'(VEC[i][23:16]) * DIV);
      @(negedge clk);
      rd(2'd0, v);
      check("R1 R3 seconds", v, VEC[i][15:8]);
      check("R3 minute carries", mins - m0, int'(VEC[i][7:0]));
      check("R1 tick count", ticks - t0, int'(VEC[i][23:16]));
    end

    // R2 fraction in hundredths, write ignored
    zero_div();
    run(37);
    rd(2'd3, v); check("R2 frac 37", v, frac_exp(37));
    run(362);
    rd(2'd3, v); check("R2 frac 399", v, 8'h99);
    wr(2'd3, 8'h55);
    rd(2'd3, v); check("R2 frac write ignored", v, 8'h99);

    // R4 command end without request has no effect
    zero_div();
    run(40);
    cmd_active = 1'b1; @(negedge clk); cmd_active = 1'b0;
    repeat (2) @(negedge clk);
    rd(2'd3, v); check("R4 no request", v, 8'h10);

    // R4 / R5 deferred software reset, counting continues
    zero_div();
    cmd_active = 1'b1;
    wr(2'd1, 8'h01);
    run(100);
    rd(2'd3, v); check("R5 counting while pending", v, 8'h25);
    rd(2'd1, v); check("R4 pending readback", v, 8'h01);
    cmd_active = 1'b0;
    @(negedge clk);
    rd(2'd3, v); check("R4 zero at command end", v, 8'h00);
    rd(2'd1, v); check("R4 self clear", v, 8'h00);

    // R6 reset keeps a pending carry
    zero_div();
    wr(2'd0, 8'h20);
    cmd_active = 1'b1;
    wr(2'd1, 8'h01);
    t0 = ticks;
    run(DIV);
    cmd_active = 1'b0;
    @(negedge clk);
    rd(2'd0, v); check("R6 carry kept", v, 8'h21);
    rd(2'd3, v); check("R6 divider zeroed", v, 8'h00);
    check("R6 tick kept", ticks - t0, 1);

    // R6 seconds write drops the pending carry
    t0 = ticks;
    run(DIV);
    wr_en = 1'b1; reg_addr = 2'd0; wr_data = 8'h42;
    @(negedge clk);
    wr_en = 1'b0; reg_addr = 2'd3;
    @(negedge clk);
    rd(2'd0, v); check("R6 write wins", v, 8'h42);
    check("R6 tick dropped", ticks - t0, 0);

    // R7 high-level event, latency of three edges
    zero_div();
    evt_pin = 1'b0;
    wr(2'd2, 8'h41);
    run(40);
    rd(2'd3, v); check("R5 counting while armed", v, 8'h10);
    evt_pin = 1'b1;
    @(negedge clk); check("R7 edge1", rd_data, 8'h10);
    @(negedge clk); check("R7 edge2", rd_data, 8'h10);
    @(negedge clk); check("R7 edge3 zero", rd_data, 8'h00);
    rd(2'd2, v); check("R7 arm self clear", v, 8'h40);

    // R8 filter bits stored, no effect on latency
    evt_pin = 1'b0;
    repeat (3) @(negedge clk);
    wr(2'd2, 8'h71);
    run(40);
    evt_pin = 1'b1;
    @(negedge clk);
    @(negedge clk); check("R8 edge2", rd_data, 8'h10);
    @(negedge clk); check("R8 edge3 zero", rd_data, 8'h00);
    rd(2'd2, v); check("R8 filter readback", v, 8'h70);

    // R7 low-level event
    wr(2'd2, 8'h01);
    run(20);
    rd(2'd3, v); check("R7 low pol idle", v, 8'h05);
    evt_pin = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 low pol zero", rd_data, 8'h00);

    // R9 cancel before event
    wr(2'd2, 8'h41);
    wr(2'd2, 8'h40);
    run(40);
    evt_pin = 1'b1;
    repeat (5) @(negedge clk);
    check("R9 cancelled", rd_data, 8'h10);
    rd(2'd2, v); check("R9 readback", v, 8'h40);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule